// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a fast input clock by a programmable total ratio P·N + A. It combines a dual-modulus prescaler, a swallow counter and a main counter. At the start of each period the swallow counter is loaded with A, and the prescaler divides by P+1 for as many prescaler cycles as the swallow counter has left. The prescaler then divides by P until the main counter, loaded with N, has seen N prescaler cycles in all. A one-cycle comparison pulse marks the end of each full period. A pair-select input chooses whether P is the small or the large modulus pair.

In a separate oscillator clock domain, a reference divider with a ratio R emits a one-cycle reference pulse every R oscillator cycles. A loop phase comparator uses the two pulse trains. All settings are sampled only at period boundaries, so a period that is already running keeps its length when software rewrites the settings. A swallow value that is not below N is clamped to N−1, and the clamp is reported on an output.

Top module: `swallow_divider`

## Requirements
- R1: With pair select high (small pair, P = 64), the comparison pulses are spaced exactly 64·N + A input clocks apart when A < N.
- R2: With pair select low (large pair, P = 128), the comparison pulses are spaced exactly 128·N + A input clocks apart when A < N.
- R3: A swallow value of 0 gives a spacing of exactly P·N input clocks for either pair.
- R4: New N, A and pair-select values are taken only at a period boundary. The period that is running when they change ends with its old spacing, and the next period uses the new values.
- R5: When A ≥ N, the block uses A = N−1, so the spacing is P·N + N − 1. clamp_o is high while the active setting is a clamped one and low otherwise.
- R6: Every comparison pulse is high for exactly one input clock.
- R7: The reference pulse is one oscillator cycle wide and repeats every R oscillator cycles, for R down to 5. A new R is taken only when the running reference period wraps.
- R8: After reset, and while en_i is low, cmp_pulse_o, ref_pulse_o and clamp_o stay low. When en_i rises again, the divider restarts with the settings present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| osc_clk_i | input | 1 | Oscillator clock for the reference divider |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| en_i | input | 1 | Run enable; low holds both dividers idle |
| main_div_i | input | 11 | Main counter ratio N (5 to 2047) |
| swallow_i | input | 7 | Swallow count A (0 to 127) |
| small_pair_i | input | 1 | 1 selects the 64/65 pair, 0 selects the 128/129 pair |
| ref_div_i | input | 14 | Reference ratio R (5 to 16383) |
| cmp_pulse_o | output | 1 | One-cycle pulse at the end of each P·N+A period |
| ref_pulse_o | output | 1 | One-cycle pulse every R oscillator cycles |
| clamp_o | output | 1 | Active setting had A ≥ N and was clamped |

## Verification
The bench builds the block with its default parameters: the 64/65 and 128/129 pairs, an 11-bit main counter, a 7-bit swallow counter and a 14-bit reference divider. N is kept between 5 and 10, so every period stays under about a thousand input clocks. This puts many measured periods of both pairs within reach, together with A = 0, A = N, A > N and settings rewritten in the middle of a period. The reference divider is measured at R = 384 and at the minimum R = 5, including a change between the two.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int unsigned DEF_P_SMALL = 64;
  localparam int unsigned DEF_P_LARGE = 128;
  localparam int unsigned DEF_N_W     = 11;
  localparam int unsigned DEF_A_W     = 7;
  localparam int unsigned DEF_R_W     = 14;
endpackage

// File: rtl/swd_prescaler.sv
module swd_prescaler #(
  parameter int unsigned P_SMALL = swd_pkg::DEF_P_SMALL,
  parameter int unsigned P_LARGE = swd_pkg::DEF_P_LARGE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic sel_small_i,
  input  logic plus1_i,
  output logic tick_o
);
  localparam int unsigned PC_W = $clog2(P_LARGE + 1);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] last;

  // terminal count of the current prescaler cycle: P-1 or P
  always_comb begin
    last   = (sel_small_i ? PC_W'(P_SMALL - 1) : PC_W'(P_LARGE - 1)) + PC_W'(plus1_i);
    tick_o = run_i && (pc_q == last);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pc_q <= '0;
    else if (!run_i || tick_o)  pc_q <= '0;
    else                        pc_q <= pc_q + PC_W'(1);
  end

  assert_pc_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (pc_q <= last));
endmodule

// File: rtl/swd_period_ctl.sv
module swd_period_ctl #(
  parameter int unsigned N_W = swd_pkg::DEF_N_W,
  parameter int unsigned A_W = swd_pkg::DEF_A_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [N_W-1:0] n_i,
  input  logic [A_W-1:0] a_i,
  input  logic           sel_i,
  input  logic           tick_i,
  output logic           run_o,
  output logic           sel_o,
  output logic           plus1_o,
  output logic           cmp_pulse_o,
  output logic           clamp_o
);
  logic           run_q, sel_q, cmp_q, clamp_q;
  logic [N_W-1:0] main_q;
  logic [A_W-1:0] swal_q;
  logic           clamp_now, bnd, reload;
  logic [A_W-1:0] a_eff;

  always_comb begin
    clamp_now = (N_W'(a_i) >= n_i);
    a_eff     = clamp_now ? A_W'(n_i - N_W'(1)) : a_i;
    bnd       = tick_i && (main_q == N_W'(1));
    reload    = (en_i && !run_q) || bnd;
    plus1_o   = (swal_q != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      sel_q   <= 1'b0;
      cmp_q   <= 1'b0;
      clamp_q <= 1'b0;
      main_q  <= '0;
      swal_q  <= '0;
    end else if (!en_i) begin
      run_q   <= 1'b0;
      cmp_q   <= 1'b0;
      clamp_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      cmp_q <= bnd;
      if (reload) begin
        main_q  <= n_i;
        swal_q  <= a_eff;
        sel_q   <= sel_i;
        clamp_q <= clamp_now;
      end else if (tick_i) begin
        main_q <= main_q - N_W'(1);
        if (plus1_o) swal_q <= swal_q - A_W'(1);
      end
    end
  end

  assign run_o       = run_q;
  assign sel_o       = sel_q;
  assign cmp_pulse_o = cmp_q;
  assign clamp_o     = clamp_q;

  assert_swallow_below_main_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (N_W'(swal_q) < main_q));
  assert_sel_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !bnd) |=> $stable(sel_q));
  assert_pulse_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_q |=> !cmp_q);
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!cmp_q && !clamp_q));
endmodule

// File: rtl/swd_ref_div.sv
module swd_ref_div #(
  parameter int unsigned R_W = swd_pkg::DEF_R_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [R_W-1:0] r_i,
  output logic           pulse_o
);
  logic           run_q, pulse_q, wrap;
  logic [R_W-1:0] cnt_q, r_q;

  assign wrap = run_q && (cnt_q == r_q - R_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      pulse_q <= 1'b0;
      cnt_q   <= '0;
      r_q     <= '0;
    end else if (!en_i) begin
      run_q   <= 1'b0;
      pulse_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      run_q   <= 1'b1;
      pulse_q <= wrap;
      if (!run_q || wrap) begin
        cnt_q <= '0;
        r_q   <= r_i;
      end else begin
        cnt_q <= cnt_q + R_W'(1);
      end
    end
  end

  assign pulse_o = pulse_q;

  assert_ref_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);
  assert_ref_cnt_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < r_q));
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int unsigned P_SMALL = swd_pkg::DEF_P_SMALL,
  parameter int unsigned P_LARGE = swd_pkg::DEF_P_LARGE,
  parameter int unsigned N_W     = swd_pkg::DEF_N_W,
  parameter int unsigned A_W     = swd_pkg::DEF_A_W,
  parameter int unsigned R_W     = swd_pkg::DEF_R_W
) (
  input  logic           clk_i,
  input  logic           osc_clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [N_W-1:0] main_div_i,
  input  logic [A_W-1:0] swallow_i,
  input  logic           small_pair_i,
  input  logic [R_W-1:0] ref_div_i,
  output logic           cmp_pulse_o,
  output logic           ref_pulse_o,
  output logic           clamp_o
);
  logic run, sel_small, plus1, tick;

  swd_prescaler #(.P_SMALL(P_SMALL), .P_LARGE(P_LARGE)) u_presc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .sel_small_i (sel_small),
    .plus1_i     (plus1),
    .tick_o      (tick)
  );

  swd_period_ctl #(.N_W(N_W), .A_W(A_W)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .n_i         (main_div_i),
    .a_i         (swallow_i),
    .sel_i       (small_pair_i),
    .tick_i      (tick),
    .run_o       (run),
    .sel_o       (sel_small),
    .plus1_o     (plus1),
    .cmp_pulse_o (cmp_pulse_o),
    .clamp_o     (clamp_o)
  );

  swd_ref_div #(.R_W(R_W)) u_ref (
    .clk_i   (osc_clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .r_i     (ref_div_i),
    .pulse_o (ref_pulse_o)
  );
endmodule

// File: tb/swallow_divider_tb_top.sv
module swallow_divider_tb_top;
  typedef struct {
    int    ratio;
    string tag;
  } exp_t;

  logic        clk = 1'b0, osc = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [10:0] main_div = 11'd5;
  logic [6:0]  swallow = 7'd3;
  logic        small_pair = 1'b1;
  logic [13:0] ref_div = 14'd384;
  logic        cmp_pulse, ref_pulse, clamp;

  always #2  clk = ~clk;
  always #10 osc = ~osc;

  swallow_divider dut_i (
    .clk_i        (clk),
    .osc_clk_i    (osc),
    .rst_ni       (rst_n),
    .en_i         (en),
    .main_div_i   (main_div),
    .swallow_i    (swallow),
    .small_pair_i (small_pair),
    .ref_div_i    (ref_div),
    .cmp_pulse_o  (cmp_pulse),
    .ref_pulse_o  (ref_pulse),
    .clamp_o      (clamp)
  );

  int   n_checks = 0, n_fails = 0;
  int   pulses = 0, since = 0, cur_ratio = 0;
  bit   meas_valid = 1'b0, finished = 1'b0;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  // monitor: interval between comparison pulses, compared against queue
  always @(negedge clk) begin
    since++;
    if (cmp_pulse) begin
      if (meas_valid && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(since == e.ratio, e.tag, since, e.ratio);
      end
      meas_valid = 1'b1;
      since = 0;
      pulses++;
    end
  end

  function automatic int ratio_of(int n, int a, bit sel);
    int p;
    p = sel ? 64 : 128;
    return p * n + ((a >= n) ? n - 1 : a);
  endfunction

  // driver: change settings just after a pulse, expect the in-flight period unchanged
  task automatic run_cfg(input int n, input int a, input bit sel, input int periods,
                         input bit exp_clamp, input string tag);
    int nr, tgt;
    exp_t e;
    nr = ratio_of(n, a, sel);
    main_div = 11'(n); swallow = 7'(a); small_pair = sel;
    e.ratio = cur_ratio; e.tag = "R4 in-flight period";
    exp_q.push_back(e);
    for (int i = 1; i < periods; i++) begin
      e.ratio = nr; e.tag = tag;
      exp_q.push_back(e);
    end
    cur_ratio = nr;
    tgt = pulses + periods;
    wait (pulses >= tgt);
    chk(clamp == exp_clamp, "R5 clamp_o", int'(clamp), int'(exp_clamp));
  endtask

  task automatic wait_ref();
    do @(negedge osc); while (!ref_pulse);
  endtask

  task automatic ref_gap(output int g);
    g = 0;
    do begin @(negedge osc); g++; end while (!ref_pulse);
  endtask

  task automatic ref_test();
    int g;
    wait_ref();
    ref_gap(g); chk(g == 384, "R7 ref R=384", g, 384);
    ref_gap(g); chk(g == 384, "R7 ref R=384", g, 384);
    ref_div = 14'd5;
    ref_gap(g); chk(g == 384, "R7 ref change deferred", g, 384);
    ref_gap(g); chk(g == 5, "R7 ref R=5", g, 5);
    ref_gap(g); chk(g == 5, "R7 ref R=5", g, 5);
  endtask

  task automatic cmp_test();
    wait (pulses >= 1);
    cur_ratio = ratio_of(5, 3, 1'b1);
    run_cfg(10, 9, 1'b1, 3, 1'b0, "R1 small pair");
    run_cfg(6, 0, 1'b0, 3, 1'b0, "R3 A=0 large pair");
    run_cfg(7, 6, 1'b0, 3, 1'b0, "R2 large pair");
    run_cfg(5, 20, 1'b1, 3, 1'b1, "R5 A>N clamped");
    run_cfg(8, 8, 1'b1, 2, 1'b1, "R5 A=N clamped");
    run_cfg(9, 0, 1'b1, 2, 1'b0, "R3 A=0 small pair");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int p0;
    repeat (5) @(negedge clk);
    chk(cmp_pulse == 1'b0, "R8 reset cmp_pulse_o", int'(cmp_pulse), 0);
    chk(ref_pulse == 1'b0, "R8 reset ref_pulse_o", int'(ref_pulse), 0);
    chk(clamp == 1'b0, "R8 reset clamp_o", int'(clamp), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    en = 1'b1;
    fork
      cmp_test();
      ref_test();
    join
    // R8: disable, confirm silence, restart with new settings
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    p0 = pulses;
    repeat (1500) @(negedge clk);
    chk(pulses == p0, "R8 no pulses while disabled", pulses - p0, 0);
    chk(clamp == 1'b0, "R8 clamp_o low while disabled", int'(clamp), 0);
    chk(ref_pulse == 1'b0, "R8 ref_pulse_o low while disabled", int'(ref_pulse), 0);
    meas_valid = 1'b0;
    main_div = 11'd6; swallow = 7'd2; small_pair = 1'b1;
    en = 1'b1;
    wait (pulses >= p0 + 1);
    cur_ratio = ratio_of(6, 2, 1'b1);
    run_cfg(6, 2, 1'b1, 3, 1'b0, "R8 restart ratio");
    chk(exp_q.size() == 0, "R4 all expected periods seen", exp_q.size(), 0);
    summary();
  end
endmodule